// File: doc/BRIEF.md
# Single-Sector Write-Back Disk Window

This block maps a byte-addressed window onto a sector-based backing store while holding only one sector locally. A requester issues loads and stores of 1, 2, 4 or 8 bytes at a byte offset into the window. The upper offset bits select a 512-byte sector, and the lower bits select a byte inside it. If the addressed sector is already in the local buffer, the access completes from the buffer. If it is not, the block first streams the buffered sector out to the backing store when it holds modified data, then reads the requested sector in, and only then completes the access.

Multi-byte values use big-endian order: the byte at the lowest offset is the most significant byte. A flush request writes a modified sector back without fetching anything. An illegal request is answered at once with an error flag and changes no state. Illegal means a bad size, an offset beyond the window, or an access that runs past the end of its sector.

The backing store receives a one-cycle command that carries a direction and a sector number. For a write-back, the block then pushes all sector bytes out in ascending order, one per cycle. For a refill, the store returns the sector bytes in ascending order at its own pace, each byte qualified by a valid strobe.

Top module: `sector_window`

## Requirements
- R1: The sector number is the window offset divided by 512 (offset bits above bit 8), and the byte position is the offset modulo 512. An 8-byte access at byte 504 of the last sector is legal and reaches the last bytes of that sector.
- R2: After reset no sector is held, `req_ready` is 1 and `rsp_valid` is 0. The first legal access of any kind issues a read command for its sector.
- R3: An access to the held sector produces no backing-store command.
- R4: On a miss while the held sector is modified, the block first issues a write command (`bk_cmd_write`=1) for the held sector and delivers exactly 512 bytes in ascending byte order. Only after that does it issue a read command for the new sector.
- R5: On a miss while the held sector is unmodified, the block issues only the read command for the new sector.
- R6: Every legal write, including one that misses, marks the held sector modified. A read never changes the modified state.
- R7: `req_bytes` gives the access size as a byte count (1, 2, 4 or 8). Read data is returned right-aligned in `rsp_rdata`, with the byte at the lowest offset as the most significant byte and the unused upper bits at zero. Write data is taken right-aligned from `req_wdata` in the same order.
- R8: A flush (`req_flush`=1) writes the held sector back with one write command when it is modified, then responds. A flush of an unmodified or empty buffer responds with no backing traffic. Flush responses carry `rsp_err`=0.
- R9: A request with `req_bytes` not in {1,2,4,8}, an offset of 4096 or more (with default parameters), or an offset plus size beyond 512 within its sector gets `rsp_err`=1 and `rsp_rdata`=0 in the cycle after acceptance. It issues no backing command and leaves the held sector and its modified state unchanged.
- R10: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance until the one-cycle `rsp_valid` pulse, and an access completes only once the buffer holds its sector.
- R11: A completed write-back, whether caused by a miss or by a flush, clears the modified state, so a later miss issues no further write-back for that data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_flush | input | 1 | Request is a flush (address, size and data ignored) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | WIN_AW+1 (13) | Byte offset into the window |
| req_bytes | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Store data, right-aligned |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response reports an illegal request |
| rsp_rdata | output | 64 | Load data, right-aligned, big-endian |
| bk_cmd_valid | output | 1 | One-cycle backing-store command |
| bk_cmd_write | output | 1 | Command direction: 1 write-back, 0 refill |
| bk_cmd_sector | output | SEC_W (3) | Sector number of the command |
| bk_wvalid | output | 1 | Write-back byte valid (one per cycle, ascending) |
| bk_wdata | output | 8 | Write-back byte |
| bk_rvalid | input | 1 | Refill byte valid |
| bk_rdata | input | 8 | Refill byte, ascending order |

## Verification
The bench targets write-back ordering on a dirty miss. A design that fetched first or skipped the write-back would leave the backing image stale, and this shows up when the old sector is read back after a later eviction. It checks that the modified state clears after both kinds of write-back and never rises on a read; a design that got this wrong would issue extra write commands, which the bench counts. Byte order is probed by storing a multi-byte value and loading single bytes and wider spans that straddle it. Accesses that end exactly on the last byte of a sector must succeed, while ones that cross it, bad sizes and offsets past the window must return an error without evicting the held sector.

// File: rtl/blkwin_pkg.sv
package blkwin_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL,
    ST_ACC
  } win_state_e;

  localparam int unsigned MAX_ACC_BYTES = 8;
  localparam int unsigned ACC_DW        = 8 * MAX_ACC_BYTES;

  function automatic logic size_legal(input logic [3:0] n);
    return (n == 4'd1) || (n == 4'd2) || (n == 4'd4) || (n == 4'd8);
  endfunction

endpackage

// File: rtl/blkwin_decode.sv
module blkwin_decode #(
  parameter  int SECTOR_BYTES = 512,
  parameter  int NUM_SECTORS  = 8,
  localparam int OFF_W        = $clog2(SECTOR_BYTES),
  localparam int WIN_BYTES    = SECTOR_BYTES * NUM_SECTORS,
  localparam int WIN_AW       = $clog2(WIN_BYTES),
  localparam int SEC_W        = $clog2(NUM_SECTORS)
) (
  input  logic [WIN_AW:0]    addr,
  input  logic [3:0]         nbytes,
  output logic [SEC_W-1:0]   sector,
  output logic [OFF_W-1:0]   offset,
  output logic               bad
);
  import blkwin_pkg::*;

  logic             in_range;
  logic             crosses;
  logic [OFF_W:0]   end_pos;

  assign sector   = SEC_W'(addr >> OFF_W);
  assign offset   = addr[OFF_W-1:0];
  assign in_range = addr < (WIN_AW+1)'(WIN_BYTES);
  assign end_pos  = (OFF_W+1)'(offset) + (OFF_W+1)'(nbytes);
  assign crosses  = end_pos > (OFF_W+1)'(SECTOR_BYTES);
  assign bad      = !size_legal(nbytes) || !in_range || crosses;

endmodule

// File: rtl/blkwin_buf.sv
module blkwin_buf #(
  parameter  int DEPTH = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [7:0]    wd,
  output logic [7:0]    rd
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd <= mem[addr];
  end

endmodule

// File: rtl/blkwin_ctrl.sv
module blkwin_ctrl #(
  parameter  int SECTOR_BYTES = 512,
  parameter  int NUM_SECTORS  = 8,
  localparam int OFF_W        = $clog2(SECTOR_BYTES),
  localparam int SEC_W        = $clog2(NUM_SECTORS),
  localparam int CNT_W        = OFF_W + 1,
  localparam int DW           = blkwin_pkg::ACC_DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_flush,
  input  logic             req_write,
  input  logic [3:0]       req_bytes,
  input  logic [DW-1:0]    req_wdata,
  input  logic [SEC_W-1:0] dec_sector,
  input  logic [OFF_W-1:0] dec_offset,
  input  logic             dec_bad,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_rdata,
  output logic [OFF_W-1:0] ram_addr,
  output logic             ram_we,
  output logic [7:0]       ram_wd,
  input  logic [7:0]       ram_rd,
  output logic             bk_cmd_valid,
  output logic             bk_cmd_write,
  output logic [SEC_W-1:0] bk_cmd_sector,
  output logic             bk_wvalid,
  input  logic             bk_rvalid,
  input  logic [7:0]       bk_rdata
);
  import blkwin_pkg::*;

  win_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             held_vld;
  logic [SEC_W-1:0] held_sec;
  logic             dirty;
  logic             pend_flush;
  logic             pend_write;
  logic [SEC_W-1:0] pend_sec;
  logic [OFF_W-1:0] pend_off;
  logic [3:0]       pend_bytes;
  logic [DW-1:0]    wsh;
  logic [DW-1:0]    acc;
  logic             rd_v;
  logic             acc_more;
  logic             hit;

  assign req_ready = (state == ST_IDLE);
  assign rsp_rdata = acc;
  assign acc_more  = cnt < CNT_W'(pend_bytes);
  assign hit       = held_vld && (held_sec == dec_sector);

  always_comb begin
    ram_addr = '0;
    ram_we   = 1'b0;
    ram_wd   = '0;
    unique case (state)
      ST_WB:   ram_addr = cnt[OFF_W-1:0];
      ST_FILL: begin
        ram_addr = cnt[OFF_W-1:0];
        ram_we   = bk_rvalid;
        ram_wd   = bk_rdata;
      end
      ST_ACC: begin
        ram_addr = pend_off + cnt[OFF_W-1:0];
        ram_we   = pend_write && acc_more;
        ram_wd   = wsh[DW-1 -: 8];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      cnt           <= '0;
      held_vld      <= 1'b0;
      held_sec      <= '0;
      dirty         <= 1'b0;
      pend_flush    <= 1'b0;
      pend_write    <= 1'b0;
      pend_sec      <= '0;
      pend_off      <= '0;
      pend_bytes    <= '0;
      wsh           <= '0;
      acc           <= '0;
      rd_v          <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_err       <= 1'b0;
      bk_cmd_valid  <= 1'b0;
      bk_cmd_write  <= 1'b0;
      bk_cmd_sector <= '0;
      bk_wvalid     <= 1'b0;
    end else begin
      rsp_valid    <= 1'b0;
      bk_cmd_valid <= 1'b0;
      bk_wvalid    <= 1'b0;
      rd_v         <= (state == ST_ACC) && !pend_write && acc_more;
      if (rd_v) acc <= {acc[DW-9:0], ram_rd};

      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            pend_flush <= req_flush;
            pend_write <= req_write;
            pend_sec   <= dec_sector;
            pend_off   <= dec_offset;
            pend_bytes <= req_bytes;
            wsh        <= req_wdata << {(4'd8 - req_bytes), 3'b000};
            acc        <= '0;
            rsp_err    <= 1'b0;
            cnt        <= '0;
            if (req_flush) begin
              if (held_vld && dirty) begin
                state         <= ST_WB;
                bk_cmd_valid  <= 1'b1;
                bk_cmd_write  <= 1'b1;
                bk_cmd_sector <= held_sec;
              end else begin
                rsp_valid <= 1'b1;
              end
            end else if (dec_bad) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
            end else if (hit) begin
              state <= ST_ACC;
            end else if (held_vld && dirty) begin
              state         <= ST_WB;
              bk_cmd_valid  <= 1'b1;
              bk_cmd_write  <= 1'b1;
              bk_cmd_sector <= held_sec;
            end else begin
              state         <= ST_FILL;
              bk_cmd_valid  <= 1'b1;
              bk_cmd_write  <= 1'b0;
              bk_cmd_sector <= dec_sector;
            end
          end
        end

        ST_WB: begin
          if (cnt < CNT_W'(SECTOR_BYTES)) begin
            cnt       <= cnt + 1'b1;
            bk_wvalid <= 1'b1;
          end else begin
            dirty <= 1'b0;
            cnt   <= '0;
            if (pend_flush) begin
              state     <= ST_IDLE;
              rsp_valid <= 1'b1;
            end else begin
              state         <= ST_FILL;
              bk_cmd_valid  <= 1'b1;
              bk_cmd_write  <= 1'b0;
              bk_cmd_sector <= pend_sec;
            end
          end
        end

        ST_FILL: begin
          if (bk_rvalid) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(SECTOR_BYTES - 1)) begin
              held_vld <= 1'b1;
              held_sec <= pend_sec;
              dirty    <= 1'b0;
              cnt      <= '0;
              state    <= ST_ACC;
            end
          end
        end

        ST_ACC: begin
          if (acc_more) begin
            cnt <= cnt + 1'b1;
            if (pend_write) begin
              wsh   <= wsh << 8;
              dirty <= 1'b1;
            end
          end else begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (bk_cmd_valid && !bk_cmd_write) |-> !dirty)
    else $error("refill issued over modified sector"); // R4

  AST_CMD_APART: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bk_cmd_valid, bk_wvalid}))
    else $error("command overlaps write-back byte"); // R4

  AST_ACC_HELD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACC) |-> (held_vld && held_sec == pend_sec))
    else $error("access without target sector"); // R10

  AST_FLUSH_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && pend_flush) |-> !dirty)
    else $error("flush left sector modified"); // R8

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> ($stable(held_vld) && $stable(held_sec) && $stable(dirty)))
    else $error("error request changed state"); // R9

  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACC && !pend_write) |=> (dirty == $past(dirty)))
    else $error("read changed modified state"); // R6

endmodule

// File: rtl/sector_window.sv
module sector_window #(
  parameter  int SECTOR_BYTES = 512,
  parameter  int NUM_SECTORS  = 8,
  localparam int OFF_W        = $clog2(SECTOR_BYTES),
  localparam int WIN_AW       = $clog2(SECTOR_BYTES * NUM_SECTORS),
  localparam int SEC_W        = $clog2(NUM_SECTORS),
  localparam int DW           = blkwin_pkg::ACC_DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_flush,
  input  logic             req_write,
  input  logic [WIN_AW:0]  req_addr,
  input  logic [3:0]       req_bytes,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_rdata,
  output logic             bk_cmd_valid,
  output logic             bk_cmd_write,
  output logic [SEC_W-1:0] bk_cmd_sector,
  output logic             bk_wvalid,
  output logic [7:0]       bk_wdata,
  input  logic             bk_rvalid,
  input  logic [7:0]       bk_rdata
);
  logic [SEC_W-1:0] dec_sector;
  logic [OFF_W-1:0] dec_offset;
  logic             dec_bad;
  logic [OFF_W-1:0] ram_addr;
  logic             ram_we;
  logic [7:0]       ram_wd;
  logic [7:0]       ram_rd;

  blkwin_decode #(.SECTOR_BYTES(SECTOR_BYTES), .NUM_SECTORS(NUM_SECTORS)) u_decode (
    .addr   (req_addr),
    .nbytes (req_bytes),
    .sector (dec_sector),
    .offset (dec_offset),
    .bad    (dec_bad)
  );

  blkwin_buf #(.DEPTH(SECTOR_BYTES)) u_buf (
    .clk  (clk),
    .addr (ram_addr),
    .we   (ram_we),
    .wd   (ram_wd),
    .rd   (ram_rd)
  );

  blkwin_ctrl #(.SECTOR_BYTES(SECTOR_BYTES), .NUM_SECTORS(NUM_SECTORS)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_flush     (req_flush),
    .req_write     (req_write),
    .req_bytes     (req_bytes),
    .req_wdata     (req_wdata),
    .dec_sector    (dec_sector),
    .dec_offset    (dec_offset),
    .dec_bad       (dec_bad),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err),
    .rsp_rdata     (rsp_rdata),
    .ram_addr      (ram_addr),
    .ram_we        (ram_we),
    .ram_wd        (ram_wd),
    .ram_rd        (ram_rd),
    .bk_cmd_valid  (bk_cmd_valid),
    .bk_cmd_write  (bk_cmd_write),
    .bk_cmd_sector (bk_cmd_sector),
    .bk_wvalid     (bk_wvalid),
    .bk_rvalid     (bk_rvalid),
    .bk_rdata      (bk_rdata)
  );

  assign bk_wdata = ram_rd;

endmodule

// File: tb/sector_window_tb_top.sv
module sector_window_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SB   = 512;
  localparam int NS   = 8;
  localparam int WIN  = SB * NS;
  localparam int AW   = $clog2(WIN) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_flush = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_bytes = '0;
  logic [63:0]   req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_err;
  logic [63:0]   rsp_rdata;
  logic          bk_cmd_valid, bk_cmd_write, bk_wvalid;
  logic [2:0]    bk_cmd_sector;
  logic [7:0]    bk_wdata;
  logic          bk_rvalid = 1'b0;
  logic [7:0]    bk_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_window #(.SECTOR_BYTES(SB), .NUM_SECTORS(NS)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_flush(req_flush),
    .req_write(req_write), .req_addr(req_addr), .req_bytes(req_bytes),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .bk_cmd_valid(bk_cmd_valid),
    .bk_cmd_write(bk_cmd_write), .bk_cmd_sector(bk_cmd_sector),
    .bk_wvalid(bk_wvalid), .bk_wdata(bk_wdata), .bk_rvalid(bk_rvalid),
    .bk_rdata(bk_rdata)
  );

  logic [7:0] store_mem [WIN];
  logic [7:0] ref_mem   [WIN];
  int n_chk = 0, n_bad = 0;
  int cmd_n = 0;
  bit log_w [64];
  int log_s [64];
  int fill_base = 0, fill_idx = 0, wb_base = 0, wb_idx = 0, tick = 0;
  bit fill_on = 0;

  // backing store model
  always @(negedge clk) begin
    if (rst) begin
      bk_rvalid = 1'b0;
      fill_on   = 0;
      fill_idx  = 0;
      wb_idx    = 0;
      tick      = 0;
      cmd_n     = 0;
    end else begin
      if (bk_rvalid) fill_idx++;
      if (fill_idx >= SB) fill_on = 0;
      if (bk_wvalid) begin
        if (wb_base + wb_idx < WIN) store_mem[wb_base + wb_idx] = bk_wdata;
        wb_idx++;
      end
      if (bk_cmd_valid) begin
        if (cmd_n < 64) begin
          log_w[cmd_n] = bk_cmd_write;
          log_s[cmd_n] = int'(bk_cmd_sector);
        end
        cmd_n++;
        if (bk_cmd_write) begin
          wb_base = int'(bk_cmd_sector) * SB;
          wb_idx  = 0;
        end else begin
          fill_base = int'(bk_cmd_sector) * SB;
          fill_idx  = 0;
          fill_on   = 1;
        end
      end
      tick++;
      if (fill_on && (tick % 5) != 0) begin
        bk_rvalid = 1'b1;
        bk_rdata  = store_mem[fill_base + fill_idx];
      end else begin
        bk_rvalid = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    check(act == exp, tag, act, exp);
  endtask

  function automatic logic [63:0] exp_rd(input int a, input int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[55:0], ref_mem[a + i]};
    return v;
  endfunction

  function automatic int sector_diffs(input int s);
    int d = 0;
    for (int i = 0; i < SB; i++) if (store_mem[s*SB + i] !== ref_mem[s*SB + i]) d++;
    return d;
  endfunction

  task automatic do_req(input bit fl, input bit wr, input int a, input int n,
                        input logic [63:0] wd, output logic [63:0] rd, output bit er);
    int  guard;
    bit  busy_ok;
    @(negedge clk);
    req_valid = 1'b1; req_flush = fl; req_write = wr;
    req_addr = AW'(a); req_bytes = 4'(n); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_flush = 1'b0; req_write = 1'b0;
    guard = 0; busy_ok = 1;
    while (!rsp_valid && guard < 5000) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
      guard++;
    end
    rd = rsp_rdata;
    er = rsp_err;
    check(busy_ok && guard < 5000, "R10 ready low until response", 64'(busy_ok), 64'd1);
    if (wr && !fl && !er)
      for (int i = 0; i < n; i++) ref_mem[a + i] = wd[8*(n-1-i) +: 8];
  endtask

  task automatic t_reset();
    check_eq("R2 ready after reset", 64'(req_ready), 64'd1);
    check_eq("R2 no response after reset", 64'(rsp_valid), 64'd0);
    check_eq("R2 no command after reset", 64'(cmd_n), 64'd0);
  endtask

  task automatic t_first_read();
    logic [63:0] d; bit e; int c0 = cmd_n;
    do_req(0, 0, 'h208, 8, '0, d, e);
    check_eq("R2 first access fetches", 64'(cmd_n - c0), 64'd1);
    check_eq("R2 fetch is read", 64'(log_w[c0]), 64'd0);
    check_eq("R1 fetch sector", 64'(log_s[c0]), 64'd1);
    check_eq("R7 first read data", d, exp_rd('h208, 8));
  endtask

  task automatic t_hits();
    logic [63:0] d; bit e; int c0 = cmd_n;
    do_req(0, 0, 'h3FF, 1, '0, d, e);
    check_eq("R7 1-byte read at last byte", d, exp_rd('h3FF, 1));
    do_req(0, 0, 'h300, 2, '0, d, e);
    check_eq("R7 2-byte read", d, exp_rd('h300, 2));
    do_req(0, 0, 'h2FC, 4, '0, d, e);
    check_eq("R7 4-byte read", d, exp_rd('h2FC, 4));
    check_eq("R3 hits no traffic", 64'(cmd_n - c0), 64'd0);
  endtask

  task automatic t_write_hit();
    logic [63:0] d; bit e; int c0 = cmd_n;
    do_req(0, 1, 'h210, 4, 64'hA1B2C3D4, d, e);
    do_req(0, 0, 'h210, 1, '0, d, e);
    check_eq("R7 big-endian msb first", d, 64'hA1);
    do_req(0, 0, 'h20E, 8, '0, d, e);
    check_eq("R7 straddling read", d, exp_rd('h20E, 8));
    do_req(0, 1, 'h3FE, 2, 64'hBEEF, d, e);
    check_eq("R1 write at sector end ok", 64'(e), 64'd0);
    do_req(0, 1, 'h200, 1, 64'h5A, d, e);
    check_eq("R3 write hits no traffic", 64'(cmd_n - c0), 64'd0);
  endtask

  task automatic t_miss_dirty();
    logic [63:0] d; bit e; int c0 = cmd_n;
    do_req(0, 0, 'hA00, 4, '0, d, e);
    check_eq("R4 two commands", 64'(cmd_n - c0), 64'd2);
    check_eq("R4 write-back first", 64'({log_w[c0], log_w[c0+1]}), 64'b10);
    check_eq("R4 write-back sector", 64'(log_s[c0]), 64'd1);
    check_eq("R1 refill sector", 64'(log_s[c0+1]), 64'd5);
    check_eq("R4 byte count", 64'(wb_idx), 64'(SB));
    check_eq("R4 stored image", 64'(sector_diffs(1)), 64'd0);
    check_eq("R7 data after refill", d, exp_rd('hA00, 4));
  endtask

  task automatic t_miss_clean();
    logic [63:0] d; bit e; int c0 = cmd_n;
    do_req(0, 0, 'h400, 8, '0, d, e);
    check_eq("R5 R6 clean miss one command", 64'(cmd_n - c0), 64'd1);
    check_eq("R5 command is read", 64'(log_w[c0]), 64'd0);
    check_eq("R5 data", d, exp_rd('h400, 8));
  endtask

  task automatic t_errors();
    logic [63:0] d; bit e; int c0 = cmd_n;
    do_req(0, 0, 'h400, 3, '0, d, e);
    check_eq("R9 bad size err", 64'(e), 64'd1);
    check_eq("R9 bad size data", d, 64'd0);
    do_req(0, 1, WIN, 1, 64'h11, d, e);
    check_eq("R9 out of window err", 64'(e), 64'd1);
    do_req(0, 0, 'h5FE, 4, '0, d, e);
    check_eq("R9 sector cross err", 64'(e), 64'd1);
    do_req(0, 0, 'h400, 0, '0, d, e);
    check_eq("R9 zero size err", 64'(e), 64'd1);
    do_req(0, 0, 'h401, 1, '0, d, e);
    check_eq("R9 held sector kept", 64'(cmd_n - c0), 64'd0);
    check_eq("R9 data intact", d, exp_rd('h401, 1));
  endtask

  task automatic t_flush();
    logic [63:0] d; bit e; int c0;
    do_req(0, 1, 'h5F8, 8, 64'h0102030405060708, d, e);
    check_eq("R1 8-byte at 504 legal", 64'(e), 64'd0);
    c0 = cmd_n;
    do_req(1, 0, 0, 0, '0, d, e);
    check_eq("R8 flush one command", 64'(cmd_n - c0), 64'd1);
    check_eq("R8 flush writes sector 2", 64'({log_w[c0], 3'(log_s[c0])}), 64'b1010);
    check_eq("R8 flush no error", 64'(e), 64'd0);
    check_eq("R8 flushed image", 64'(sector_diffs(2)), 64'd0);
    c0 = cmd_n;
    do_req(1, 0, 0, 0, '0, d, e);
    check_eq("R8 clean flush quiet", 64'(cmd_n - c0), 64'd0);
    c0 = cmd_n;
    do_req(0, 0, 'hE00, 2, '0, d, e);
    check_eq("R11 no write-back after flush", 64'(cmd_n - c0), 64'd1);
    c0 = cmd_n;
    do_req(0, 0, 'h5F8, 8, '0, d, e);
    check_eq("R11 clean refill", 64'(cmd_n - c0), 64'd1);
    check_eq("R1 last bytes of sector", d, 64'h0102030405060708);
  endtask

  task automatic t_write_miss();
    logic [63:0] d; bit e; int c0 = cmd_n;
    do_req(0, 1, 'hFFC, 4, 64'hCAFEF00D, d, e);
    check_eq("R6 write miss fetches", 64'(cmd_n - c0), 64'd1);
    c0 = cmd_n;
    do_req(0, 0, 'h007, 1, '0, d, e);
    check_eq("R6 write miss left dirty", 64'(cmd_n - c0), 64'd2);
    check_eq("R6 evicted sector 7", 64'(log_s[c0]), 64'd7);
    check_eq("R6 evicted image", 64'(sector_diffs(7)), 64'd0);
    check_eq("R7 sector 0 byte", d, exp_rd('h007, 1));
  endtask

  initial begin
    for (int a = 0; a < WIN; a++) begin
      store_mem[a] = 8'(a * 13 + (a >> 9) * 7 + 5);
      ref_mem[a]   = store_mem[a];
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_read();
    t_hits();
    t_write_hit();
    t_miss_dirty();
    t_miss_clean();
    t_errors();
    t_flush();
    t_write_miss();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule